// File: doc/BRIEF.md
# Presettable Two-Section Ripple Counter

This block is a four-stage counter built from two sections. Each section has its own count input. The low section divides by two and drives bit 0 of the output. The high section drives bits 3..1. A parameter selects whether the high section divides by five (decade variant) or by eight (binary variant). The whole block runs in one system-clock domain. The count inputs, the load strobe and the load data pass through synchronizers. A detected HIGH-to-LOW transition on a synchronized count input acts as a one-cycle count enable.

The two sections can be chained inside the block, which is chosen by a parameter.
- Low-into-high chaining gives 8-4-2-1 BCD counting in the decade variant and modulo-16 counting in the binary variant.
- High-into-low chaining in the decade variant gives bi-quinary counting, where bit 0 toggles once every five counts and so has a 50% duty cycle.
- With no chaining, the two sections count independently.

An active-LOW clear forces all four outputs LOW at once and overrides everything else. An active-LOW load copies the data inputs into the stages and overrides counting. While the load input is held LOW the outputs track the data inputs, so the block can also serve as a transparent 4-bit latch.

Top module: `dual_section_counter`

## Requirements
- R1: A section advances only on a HIGH-to-LOW transition of its count input. The new value appears on the third rising system-clock edge after that transition. A LOW-to-HIGH transition has no effect.
- R2: The low section toggles q[0] on each advance.
- R3: In the decade variant the high section (q[3:1]) steps 000, 001, 010, 011, 100 and then back to 000.
- R4: In the binary variant the high section counts 000 to 111 and wraps to 000.
- R5: In the decade variant, a high section holding 101, 110 or 111 goes to 000 on its next advance.
- R6: When mr_n goes LOW, q becomes 0000 before the next rising clock edge. q stays 0000 while mr_n is LOW, whatever the other inputs do.
- R7: While pl_n is LOW (and mr_n is HIGH), q takes the value of p, with p[i] going to q[i], and count transitions are ignored.
- R8: While pl_n stays LOW, a change on p reaches q. After pl_n returns HIGH, q holds its last loaded value while p changes.
- R9: With low-into-high chaining, q counts 0 to 9 and back to 0 in the decade variant, and 0 to 15 and back to 0 in the binary variant. The high section advances in the same system cycle in which q[0] falls.
- R10: With high-into-low chaining in the decade variant, the value after m counts is q[3:1] = m mod 5 and q[0] = (m/5) mod 2. Over any ten consecutive counts, q[0] is HIGH after exactly five of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| mr_n | input | 1 | Active-LOW clear: asserts asynchronously, releases through a synchronizer |
| pl_n | input | 1 | Active-LOW load / latch-transparent strobe |
| cp0 | input | 1 | Low-section count input (falling transition counts); ignored with high-into-low chaining |
| cp1 | input | 1 | High-section count input (falling transition counts); ignored with low-into-high chaining |
| p | input | 4 | Load data, p[i] goes to q[i] |
| q | output | 4 | Counter state: q[0] low section, q[3:1] high section |

## Verification
The assertions assume that the count inputs, the load strobe and the load data are slow compared with the system clock. Each level is taken to hold for several system cycles, so that every transition passes through the synchronizers as one clean edge, and the load data is taken to be stable around any change of the load strobe. The stimulus holds every input level for at least five system cycles and changes p only while pl_n is either held steady or was changed several cycles earlier. In this way the assertions never see a transition shorter than the synchronizer depth.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   localparam int Q_W  = 4;
   localparam int HI_W = Q_W - 1;

   typedef enum logic [1:0] {
      CHAIN_NONE     = 2'd0,
      CHAIN_LO_TO_HI = 2'd1,
      CHAIN_HI_TO_LO = 2'd2
   } chain_e;
endpackage

// File: rtl/dsc_rst_sync.sv
module dsc_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_ok
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign rst_ok = chain[STAGES-1];
endmodule

// File: rtl/dsc_sync.sv
module dsc_sync #(
   parameter int               WIDTH  = 1,
   parameter int               STAGES = 2,
   parameter logic [WIDTH-1:0] IDLE   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{IDLE}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/dsc_fall_det.sv
module dsc_fall_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic fall
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= lvl;
   end

   assign fall = prev & ~lvl;
endmodule

// File: rtl/dsc_lo_stage.sv
module dsc_lo_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic load,
   input  logic d,
   output logic q0,
   output logic fall_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q0 <= 1'b0;
      else if (load) q0 <= d;
      else if (en)   q0 <= ~q0;
   end

   // the output falls at the next edge
   assign fall_o = en & ~load & q0;

   AST_LO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !load) |=> (q0 != $past(q0)));   // R2
   AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load) |=> $stable(q0));        // R1
endmodule

// File: rtl/dsc_hi_stage.sv
module dsc_hi_stage #(
   parameter bit DECADE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic                  load,
   input  logic [dsc_pkg::HI_W-1:0] d,
   output logic [dsc_pkg::HI_W-1:0] q,
   output logic                  msb_fall_o
);
   localparam int W = dsc_pkg::HI_W;
   localparam logic [W-1:0] LAST_DEC = W'(4);

   logic [W-1:0] nxt;

   if (DECADE) begin : g_div5
      always_comb begin
         if (q >= LAST_DEC) nxt = '0;
         else               nxt = q + W'(1);
      end

      AST_HI_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         (en && !load) |=> (q <= LAST_DEC));          // R5
      AST_HI_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         (en && !load && q < LAST_DEC) |=> (q == $past(q) + W'(1)));  // R3
   end else begin : g_div8
      always_comb nxt = q + W'(1);

      AST_HI_BIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         (en && !load) |=> (q == $past(q) + W'(1)));  // R4
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
      else if (en)   q <= nxt;
   end

   assign msb_fall_o = en & ~load & q[W-1] & ~nxt[W-1];

   AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load) |=> $stable(q));                 // R1
endmodule

// File: rtl/dual_section_counter.sv
module dual_section_counter #(
   parameter bit              DECADE      = 1'b1,
   parameter dsc_pkg::chain_e CHAIN       = dsc_pkg::CHAIN_NONE,
   parameter int              SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       mr_n,
   input  logic       pl_n,
   input  logic       cp0,
   input  logic       cp1,
   input  logic [3:0] p,
   output logic [3:0] q
);
   localparam int QW  = dsc_pkg::Q_W;
   localparam int HW  = dsc_pkg::HI_W;
   localparam int LDW = QW + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (QW != 4) begin : g_bad_width
      $error("counter width must be 4");
   end
   if (!DECADE && CHAIN == dsc_pkg::CHAIN_HI_TO_LO) begin : g_note_bq
      // allowed: q[0] then divides the high-section wrap by two
   end

   logic          rst_ok;
   logic [1:0]    cp_s;
   logic [LDW-1:0] ld_s;
   logic          pl_act;
   logic [QW-1:0] p_s;
   logic          cp0_fall, cp1_fall;
   logic          lo_en, hi_en;
   logic          lo_fall, hi_msb_fall;
   logic          q0;
   logic [HW-1:0] qh;

   dsc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk(clk), .arst_n(mr_n), .rst_ok(rst_ok)
   );

   dsc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .IDLE(2'b11)) u_cp_sync (
      .clk(clk), .rst_n(rst_ok), .d({cp1, cp0}), .q(cp_s)
   );

   dsc_sync #(.WIDTH(LDW), .STAGES(SYNC_STAGES), .IDLE({1'b1, {QW{1'b0}}})) u_ld_sync (
      .clk(clk), .rst_n(rst_ok), .d({pl_n, p}), .q(ld_s)
   );

   assign pl_act = ~ld_s[LDW-1];
   assign p_s    = ld_s[QW-1:0];

   dsc_fall_det u_fd0 (.clk(clk), .rst_n(rst_ok), .lvl(cp_s[0]), .fall(cp0_fall));
   dsc_fall_det u_fd1 (.clk(clk), .rst_n(rst_ok), .lvl(cp_s[1]), .fall(cp1_fall));

   if (CHAIN == dsc_pkg::CHAIN_LO_TO_HI) begin : g_lo_hi
      logic unused_sink;
      assign lo_en       = cp0_fall;
      assign hi_en       = lo_fall;
      assign unused_sink = cp1_fall ^ hi_msb_fall;

      AST_CHAIN_LO_HI: assert property (@(posedge clk) disable iff (!rst_ok)
         (q0 && lo_en && !pl_act) |=> (qh != $past(qh)));   // R9
   end else if (CHAIN == dsc_pkg::CHAIN_HI_TO_LO) begin : g_hi_lo
      logic unused_sink;
      assign hi_en       = cp1_fall;
      assign lo_en       = hi_msb_fall;
      assign unused_sink = cp0_fall ^ lo_fall;

      AST_CHAIN_HI_LO: assert property (@(posedge clk) disable iff (!rst_ok)
         ($fell(qh[HW-1]) && !$past(pl_act)) |-> (q0 != $past(q0)));  // R10
   end else begin : g_free
      logic unused_sink;
      assign lo_en       = cp0_fall;
      assign hi_en       = cp1_fall;
      assign unused_sink = lo_fall ^ hi_msb_fall;
   end

   dsc_lo_stage u_lo (
      .clk(clk), .rst_n(rst_ok), .en(lo_en), .load(pl_act),
      .d(p_s[0]), .q0(q0), .fall_o(lo_fall)
   );

   dsc_hi_stage #(.DECADE(DECADE)) u_hi (
      .clk(clk), .rst_n(rst_ok), .en(hi_en), .load(pl_act),
      .d(p_s[QW-1:1]), .q(qh), .msb_fall_o(hi_msb_fall)
   );

   assign q = {qh, q0};

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_ok)
      pl_act |=> (q == $past(p_s)));          // R7
   AST_CLEAR_HELD: assert property (@(posedge clk) disable iff (!mr_n)
      $rose(rst_ok) |-> (q == '0));            // R6
endmodule

// File: tb/dual_section_counter_test.sv
`timescale 1ns/1ps
module dual_section_counter_test;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       mr_n = 1'b0;
   logic       pl_n = 1'b1;
   logic [3:0] p    = 4'd0;
   logic a_cp0 = 1'b1, a_cp1 = 1'b1, b_cp0 = 1'b1, c_cp0 = 1'b1, d_cp1 = 1'b1;
   logic [3:0] q_a, q_b, q_c, q_d;

   int checks = 0;
   int errors = 0;

   int         unit_q[$];
   logic [3:0] exp_q[$];
   string      req_q[$];

   // free-running decade counter
   dual_section_counter #(.DECADE(1'b1), .CHAIN(dsc_pkg::CHAIN_NONE)) uut (
      .clk(clk), .mr_n(mr_n), .pl_n(pl_n), .cp0(a_cp0), .cp1(a_cp1), .p(p), .q(q_a));
   // BCD
   dual_section_counter #(.DECADE(1'b1), .CHAIN(dsc_pkg::CHAIN_LO_TO_HI)) uut_bcd (
      .clk(clk), .mr_n(mr_n), .pl_n(pl_n), .cp0(b_cp0), .cp1(1'b1), .p(p), .q(q_b));
   // modulo 16
   dual_section_counter #(.DECADE(1'b0), .CHAIN(dsc_pkg::CHAIN_LO_TO_HI)) uut_bin (
      .clk(clk), .mr_n(mr_n), .pl_n(pl_n), .cp0(c_cp0), .cp1(1'b1), .p(p), .q(q_c));
   // bi-quinary
   dual_section_counter #(.DECADE(1'b1), .CHAIN(dsc_pkg::CHAIN_HI_TO_LO)) uut_bq (
      .clk(clk), .mr_n(mr_n), .pl_n(pl_n), .cp0(1'b1), .cp1(d_cp1), .p(p), .q(q_d));

   function automatic logic [3:0] observe(input int unit);
      case (unit)
         0:       return q_a;
         1:       return q_b;
         2:       return q_c;
         default: return q_d;
      endcase
   endfunction

   // monitor: pops expected items and compares away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         while (unit_q.size() > 0) begin
            int         u;
            logic [3:0] e, o;
            string      r;
            u = unit_q.pop_front();
            e = exp_q.pop_front();
            r = req_q.pop_front();
            o = observe(u);
            checks++;
            if (o !== e) begin
               errors++;
               $display("FAIL %s unit %0d: actual %b expected %b", r, u, o, e);
            end
         end
      end
   end

   task automatic expect_q(input int unit, input logic [3:0] e, input string r);
      unit_q.push_back(unit);
      exp_q.push_back(e);
      req_q.push_back(r);
      wait (unit_q.size() == 0);
   endtask

   task automatic settle();
      repeat (5) @(posedge clk);
      #1;
   endtask

   task automatic set_cp(input int which, input logic v);
      case (which)
         0: a_cp0 = v;
         1: a_cp1 = v;
         2: b_cp0 = v;
         3: c_cp0 = v;
         default: d_cp1 = v;
      endcase
   endtask

   task automatic pulse(input int which, input int n);
      for (int i = 0; i < n; i++) begin
         set_cp(which, 1'b0);
         settle();
         set_cp(which, 1'b1);
         settle();
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int hi_cnt;
      // R6 reset state on every variant
      repeat (3) @(posedge clk);
      #1;
      for (int u = 0; u < 4; u++) expect_q(u, 4'b0000, "R6 reset");
      mr_n = 1'b1;
      settle();

      // R2 low section divide by two
      pulse(0, 1);
      expect_q(0, 4'b0001, "R2 first toggle");
      pulse(0, 1);
      expect_q(0, 4'b0000, "R2 second toggle");

      // R1 falling counts, rising does not
      set_cp(0, 1'b0);
      settle();
      expect_q(0, 4'b0001, "R1 falling transition");
      set_cp(0, 1'b1);
      settle();
      expect_q(0, 4'b0001, "R1 rising ignored");
      pulse(0, 1);
      expect_q(0, 4'b0000, "R2 back to zero");

      // R3 divide by five
      for (int k = 1; k <= 5; k++) begin
         pulse(1, 1);
         expect_q(0, {3'(k % 5), 1'b0}, "R3 decade step");
      end

      // R9 BCD order
      for (int n = 1; n <= 10; n++) begin
         pulse(2, 1);
         expect_q(1, 4'(n % 10), "R9 BCD");
      end

      // R4 R9 modulo 16
      for (int n = 1; n <= 16; n++) begin
         pulse(3, 1);
         expect_q(2, 4'(n % 16), "R4 R9 binary");
      end

      // R10 bi-quinary
      hi_cnt = 0;
      for (int m = 1; m <= 20; m++) begin
         pulse(4, 1);
         expect_q(3, {3'(m % 5), 1'((m / 5) % 2)}, "R10 bi-quinary");
         if (m > 10 && q_d[0]) hi_cnt++;
      end
      checks++;
      if (hi_cnt != 5) begin
         errors++;
         $display("FAIL R10 duty: actual %0d expected %0d", hi_cnt, 5);
      end

      // R7 load, and it beats counting
      p = 4'b1010;
      pl_n = 1'b0;
      settle();
      expect_q(0, 4'b1010, "R7 load");
      pulse(0, 1);
      pulse(1, 1);
      expect_q(0, 4'b1010, "R7 count ignored under load");

      // R8 transparent then held
      p = 4'b0101;
      settle();
      expect_q(0, 4'b0101, "R8 follows data");
      pl_n = 1'b1;
      settle();
      p = 4'b1111;
      settle();
      expect_q(0, 4'b0101, "R8 holds after release");

      // R5 illegal high states
      p = 4'b1011; pl_n = 1'b0; settle(); pl_n = 1'b1; settle();
      pulse(1, 1);
      expect_q(0, 4'b0001, "R5 from 101");
      p = 4'b1100; pl_n = 1'b0; settle(); pl_n = 1'b1; settle();
      pulse(1, 1);
      expect_q(0, 4'b0000, "R5 from 110");
      p = 4'b1111; pl_n = 1'b0; settle(); pl_n = 1'b1; settle();
      pulse(1, 1);
      expect_q(0, 4'b0001, "R5 from 111");

      // R6 clear mid-count, wins over load
      pulse(0, 1);
      pulse(1, 2);
      expect_q(0, 4'b0100, "R6 pre-clear count");
      @(posedge clk);
      #1;
      p = 4'b1111;
      pl_n = 1'b0;
      mr_n = 1'b0;
      expect_q(0, 4'b0000, "R6 immediate clear");
      settle();
      expect_q(0, 4'b0000, "R6 clear beats load");
      mr_n = 1'b1;
      settle();
      expect_q(0, 4'b1111, "R7 load after clear release");
      pl_n = 1'b1;
      settle();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule